// File: doc/BRIEF.md
# Serial Control Register File with Peak-Level Readback

This block is the control slave of a multichannel audio converter. A host drives a four-wire serial link made up of a clock, an active-low frame latch, a data input and a data output. Each frame the host sends is 16 bits long, most significant bit first. The block decodes each frame into a write or a read of a sixteen-entry register space. Eight ten-bit volume registers and five ten-bit control registers sit in that space, and their contents drive parallel configuration buses to the datapath.

Two read-only registers report the loudest level seen on each of two input channels. The datapath supplies each channel's level as a precomputed six-bit attenuation code, where 0 means full scale and 63 means -63 dB. The block keeps the smallest code seen. Reading a peak register returns that code and restarts tracking.

The serial clock is asynchronous to the system clock. The three serial inputs are brought into the system clock domain by synchronizers, and the block detects serial clock edges by oversampling.

Top module: `spireg_top`

## Requirements
- R1: A frame holds address in bits 15..12, a direction bit in bit 11 (1 = write, 0 = read), a reserved bit in bit 10 and data in bits 9..0. A write takes effect once the 16th rising serial clock edge of the frame has been sampled.
- R2: After reset, volume registers (addresses 2..9) hold 0x3FF, control registers (addresses 0, 1, 12, 13, 14) hold 0, and both peak registers hold code 63.
- R3: In a read frame, `miso_o` shifts out the addressed register's bits 9..0, most significant bit first, during frame bits 9..0. Each bit changes after a falling serial clock edge, so the host samples it on the next rising edge. `miso_o` is 0 before that point.
- R4: `miso_oe_o` is high only while the latch is low.
- R5: Writes to addresses 10, 11 and 15 change nothing. Address 15 reads as 0.
- R6: A frame whose reserved bit is 1 writes nothing, reads back as 0 and does not clear a peak register.
- R7: A frame that ends before its 16th rising edge writes nothing. Bits after the 16th are ignored.
- R8: While bit 5 of address 14 is 1, each peak register takes the smaller of its value and every valid level code on its channel. While that bit is 0, level inputs are ignored.
- R9: A read of address 10 (channel 0) or 11 (channel 1) returns the peak code in bits 9..4, with bits 3..0 zero.
- R10: A read of a peak register resets it to 63 once the header has been received. If a valid, enabled level arrives in that same cycle, the register loads that level instead, so tracking continues without a gap.
- R11: `vol_o` and `ctl_o` always show the current register contents. Volume for address 2+k is in slice k of `vol_o`. Control slices 0..4 of `ctl_o` hold addresses 0, 1, 12, 13 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial control clock, idles low |
| latch_i | input | 1 | Frame latch, low during a frame |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for miso_o |
| lvl_i | input | 12 | Level codes, channel c in bits 6c+5..6c |
| lvl_vld_i | input | 2 | Level valid per channel |
| vol_o | output | 80 | Volume registers, ten bits each |
| ctl_o | output | 50 | Control registers, ten bits each |

## Verification
The hardest case to reach is a peak read whose clear lands in the same system cycle as a valid level sample. The capture point sits behind the input synchronizers, so its cycle cannot be aimed at from the ports. The stimulus therefore holds the level valid continuously across the whole read frame. The outcome then does not depend on the cycle: the read must return the older minimum, and the register must hold the held level afterwards rather than 63. Frames with a set reserved bit, truncated frames and overlong frames are mixed between ordinary writes. A reference model of the register file is compared against the configuration buses on every idle clock.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 10;
    localparam int PEAK_W     = 6;
    localparam int NUM_VOL    = 8;
    localparam int NUM_CTL    = 5;
    localparam int NUM_PEAK   = 2;
    localparam int HDR_BITS   = FRAME_BITS - DATA_W;
    localparam int RW_POS     = DATA_W + 1;
    localparam int RSV_POS    = DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int VOL_IW     = $clog2(NUM_VOL);
    localparam int PAD_W      = DATA_W - PEAK_W;

    localparam logic [ADDR_W-1:0] A_VOL_FIRST = 4'd2;
    localparam logic [ADDR_W-1:0] A_VOL_LAST  = 4'd9;
    localparam logic [ADDR_W-1:0] A_PEAK0     = 4'd10;
    localparam logic [ADDR_W-1:0] A_PEAK1     = 4'd11;
    localparam logic [ADDR_W-1:0] A_RSVD      = 4'd15;
    localparam int PKEN_SLOT = 4;
    localparam int PKEN_BIT  = 5;

    localparam logic [DATA_W-1:0] VOL_RST   = 10'h3FF;
    localparam logic [PEAK_W-1:0] PEAK_IDLE = 6'd63;

    typedef struct packed {
        logic [FRAME_BITS-2:0] sh;
        logic [CNT_W-1:0]      cnt;
        logic [DATA_W-1:0]     osh;
        logic                  sck_p;
        logic                  oe;
    } frm_st_t;

    typedef struct packed {
        logic [NUM_VOL-1:0][DATA_W-1:0]  vol;
        logic [NUM_CTL-1:0][DATA_W-1:0]  ctl;
        logic [NUM_PEAK-1:0][PEAK_W-1:0] peak;
    } bank_st_t;

    // Returns {valid, slot} for the writable control addresses.
    function automatic logic [3:0] ctl_slot(input logic [ADDR_W-1:0] a);
        case (a)
            4'd0:    return 4'b1_000;
            4'd1:    return 4'b1_001;
            4'd12:   return 4'b1_010;
            4'd13:   return 4'b1_011;
            4'd14:   return 4'b1_100;
            default: return 4'b0_000;
        endcase
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb st_d = d_i;
        end else begin : g_chain
            always_comb st_d = {st_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= {STAGES{RST}};
        else         st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sck_i,
    input  logic              lat_i,
    input  logic              din_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              miso_o,
    output logic              oe_o
);

    frm_st_t q, n;
    logic [FRAME_BITS-1:0] word;
    logic rise, fall;

    always_comb begin
        n        = q;
        wr_en_o  = 1'b0;
        rd_req_o = 1'b0;
        rise     = sck_i & ~q.sck_p;
        fall     = ~sck_i & q.sck_p;
        word     = {q.sh, din_i};
        n.sck_p  = sck_i;
        n.oe     = ~lat_i;
        if (lat_i) begin
            n.sh  = '0;
            n.cnt = '0;
            n.osh = '0;
        end else if (rise && q.cnt < CNT_W'(FRAME_BITS)) begin
            n.sh  = word[FRAME_BITS-2:0];
            n.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(FRAME_BITS - 1) && word[RW_POS] && !word[RSV_POS])
                wr_en_o = 1'b1;
        end else if (fall) begin
            if (q.cnt == CNT_W'(HDR_BITS)) begin
                if (!q.sh[1] && !q.sh[0]) begin
                    rd_req_o = 1'b1;
                    n.osh    = rd_data_i;
                end
            end else if (q.cnt > CNT_W'(HDR_BITS)) begin
                n.osh = {q.osh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign wr_addr_o = word[FRAME_BITS-1 -: ADDR_W];
    assign wr_data_o = word[DATA_W-1:0];
    assign rd_addr_o = q.sh[HDR_BITS-1 -: ADDR_W];
    assign miso_o    = q.osh[DATA_W-1];
    assign oe_o      = q.oe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.sh    <= '0;
            q.cnt   <= '0;
            q.osh   <= '0;
            q.sck_p <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= n;
        end
    end

    AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= CNT_W'(FRAME_BITS)); // R7

    AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cnt < CNT_W'(HDR_BITS)) |-> !miso_o); // R3

    AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_i && $past(lat_i)) |-> !oe_o); // R4

endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic                          rd_req_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o,
    input  logic [NUM_PEAK*PEAK_W-1:0]    lvl_i,
    input  logic [NUM_PEAK-1:0]           lvl_vld_i,
    output logic [NUM_VOL*DATA_W-1:0]     vol_o,
    output logic [NUM_CTL*DATA_W-1:0]     ctl_o
);

    bank_st_t q, n;
    logic              pk_en;
    logic [3:0]        wslot, rslot;
    logic [VOL_IW-1:0] wvi, rvi;
    logic              w_vol, r_vol;

    assign pk_en = q.ctl[PKEN_SLOT][PKEN_BIT];
    assign wslot = ctl_slot(wr_addr_i);
    assign rslot = ctl_slot(rd_addr_i);
    assign wvi   = VOL_IW'(wr_addr_i - A_VOL_FIRST);
    assign rvi   = VOL_IW'(rd_addr_i - A_VOL_FIRST);
    assign w_vol = (wr_addr_i >= A_VOL_FIRST) && (wr_addr_i <= A_VOL_LAST);
    assign r_vol = (rd_addr_i >= A_VOL_FIRST) && (rd_addr_i <= A_VOL_LAST);

    always_comb begin
        n = q;
        for (int c = 0; c < NUM_PEAK; c++) begin
            logic [PEAK_W-1:0] lv;
            logic clr, smp;
            lv  = lvl_i[c*PEAK_W +: PEAK_W];
            clr = rd_req_i && (rd_addr_i == ADDR_W'(A_PEAK0 + c));
            smp = pk_en && lvl_vld_i[c];
            if (clr)
                n.peak[c] = smp ? lv : PEAK_IDLE;
            else if (smp && lv < q.peak[c])
                n.peak[c] = lv;
        end
        if (wr_en_i) begin
            if (w_vol)
                n.vol[wvi] = wr_data_i;
            else if (wslot[3])
                n.ctl[wslot[2:0]] = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (r_vol)
            rd_data_o = q.vol[rvi];
        else if (rslot[3])
            rd_data_o = q.ctl[rslot[2:0]];
        else if (rd_addr_i == A_PEAK0 || rd_addr_i == A_PEAK1)
            rd_data_o = {q.peak[rd_addr_i[0]], {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.vol  <= {NUM_VOL{VOL_RST}};
            q.ctl  <= '0;
            q.peak <= {NUM_PEAK{PEAK_IDLE}};
        end else begin
            q <= n;
        end
    end

    generate
        for (genvar k = 0; k < NUM_VOL; k++) begin : g_vol
            assign vol_o[k*DATA_W +: DATA_W] = q.vol[k];
        end
        for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
            assign ctl_o[k*DATA_W +: DATA_W] = q.ctl[k];
        end
        for (genvar c = 0; c < NUM_PEAK; c++) begin : g_pk_chk
            AST_PEAK_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(rd_req_i && rd_addr_i == ADDR_W'(A_PEAK0 + c)) |=>
                    q.peak[c] <= $past(q.peak[c])); // R8
            AST_PEAK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (rd_req_i && rd_addr_i == ADDR_W'(A_PEAK0 + c) && !lvl_vld_i[c]) |=>
                    q.peak[c] == PEAK_IDLE); // R10
        end
    endgenerate

    AST_RO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i == A_PEAK0 || wr_addr_i == A_PEAK1 || wr_addr_i == A_RSVD))
            |=> ($stable(vol_o) && $stable(ctl_o))); // R5

    AST_VOL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && w_vol) |=> vol_o[$past(wvi)*DATA_W +: DATA_W] == $past(wr_data_i)); // R1

endmodule

// File: rtl/spireg_top.sv
module spireg_top
    import spireg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sclk_i,
    input  logic                       latch_i,
    input  logic                       mosi_i,
    output logic                       miso_o,
    output logic                       miso_oe_o,
    input  logic [NUM_PEAK*PEAK_W-1:0] lvl_i,
    input  logic [NUM_PEAK-1:0]        lvl_vld_i,
    output logic [NUM_VOL*DATA_W-1:0]  vol_o,
    output logic [NUM_CTL*DATA_W-1:0]  ctl_o
);

    logic [2:0]        pins_s;
    logic              wr_en, rd_req;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    spireg_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST    (3'b010)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({sclk_i, latch_i, mosi_i}),
        .q_o    (pins_s)
    );

    spireg_frame u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sck_i     (pins_s[2]),
        .lat_i     (pins_s[1]),
        .din_i     (pins_s[0]),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_req_o  (rd_req),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .miso_o    (miso_o),
        .oe_o      (miso_oe_o)
    );

    spireg_bank u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_req_i  (rd_req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .lvl_i     (lvl_i),
        .lvl_vld_i (lvl_vld_i),
        .vol_o     (vol_o),
        .ctl_o     (ctl_o)
    );

endmodule

// File: tb/sim_spireg_top.sv
module sim_spireg_top;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, latch = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;
    logic [11:0] lvl = '0;
    logic [1:0]  lvl_vld = '0;
    logic [79:0] vol;
    logic [49:0] ctl;

    int total = 0, bad = 0;
    bit done = 0, cmp_en = 0;

    logic [9:0] m_vol [8];
    logic [9:0] m_ctl [5];
    int         m_peak [2];

    always #5 clk = ~clk;

    spireg_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .latch_i(latch), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .lvl_i(lvl), .lvl_vld_i(lvl_vld),
        .vol_o(vol), .ctl_o(ctl)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int slot(input logic [3:0] a);
        case (a)
            4'd0: return 0;  4'd1: return 1;  4'd12: return 2;
            4'd13: return 3; 4'd14: return 4; default: return -1;
        endcase
    endfunction

    function automatic int exp_rd(input logic [3:0] a);
        if (a >= 2 && a <= 9) return int'(m_vol[a-2]);
        if (slot(a) >= 0)     return int'(m_ctl[slot(a)]);
        if (a == 10 || a == 11) return m_peak[a-10] << 4;
        return 0;
    endfunction

    // Cycle-by-cycle comparison of the configuration buses while idle (R11).
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int k = 0; k < 8; k++) chk("R11", "vol bus", int'(vol[k*10 +: 10]), int'(m_vol[k]));
            for (int k = 0; k < 5; k++) chk("R11", "ctl bus", int'(ctl[k*10 +: 10]), int'(m_ctl[k]));
        end
    end

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [9:0] rv);
        rv = '0;
        cmp_en = 0;
        @(negedge clk) latch = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 16) ? w[15-b] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (b >= 6 && b < 16) rv[15-b] = miso;
            if (b == 3) chk("R4", "oe in frame", int'(miso_oe), 1);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        latch = 1'b1;
        repeat (8) @(negedge clk);
        chk("R4", "oe after latch", int'(miso_oe), 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [9:0] d, input bit rsv, input int nbits);
        logic [9:0] rv;
        xfer({a, 1'b1, rsv, d}, nbits, rv);
        if (!rsv && nbits >= 16) begin
            if (a >= 2 && a <= 9) m_vol[a-2] = d;
            else if (slot(a) >= 0) m_ctl[slot(a)] = d;
        end
        cmp_en = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        logic [9:0] rv;
        int e;
        e = exp_rd(a);
        xfer({a, 1'b0, 1'b0, 10'h0}, 16, rv);
        chk(req, "read data", int'(rv), e);
        if (a == 10 || a == 11) m_peak[a-10] = 63;
        cmp_en = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int ch, input int v);
        @(negedge clk);
        lvl[ch*6 +: 6] = 6'(v);
        lvl_vld[ch] = 1'b1;
        @(negedge clk);
        lvl_vld[ch] = 1'b0;
        if (m_ctl[4][5] && v < m_peak[ch]) m_peak[ch] = v;
    endtask

    initial begin
        logic [9:0] rv;
        for (int k = 0; k < 8; k++) m_vol[k] = 10'h3FF;
        for (int k = 0; k < 5; k++) m_ctl[k] = '0;
        m_peak[0] = 63; m_peak[1] = 63;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R2: reset state at the ports
        chk("R2", "vol0 reset", int'(vol[9:0]), 'h3FF);
        chk("R2", "ctl0 reset", int'(ctl[9:0]), 0);
        chk("R4", "oe at reset", int'(miso_oe), 0);
        cmp_en = 1;
        rd(4'd2, "R2");
        rd(4'd14, "R2");
        rd(4'd11, "R9");
        // R1, R3: writes then read-back
        wr(4'd5, 10'h155, 0, 16);
        wr(4'd9, 10'h000, 0, 16);
        wr(4'd0, 10'h2AA, 0, 16);
        wr(4'd13, 10'h1C3, 0, 16);
        rd(4'd5, "R3");
        rd(4'd9, "R1");
        rd(4'd0, "R3");
        rd(4'd13, "R1");
        // R5: read-only and reserved addresses
        wr(4'd10, 10'h001, 0, 16);
        wr(4'd15, 10'h3FF, 0, 16);
        rd(4'd15, "R5");
        rd(4'd10, "R5");
        // R6: reserved bit set
        wr(4'd3, 10'h0F0, 1, 16);
        rd(4'd3, "R6");
        // R7: short and long frames
        wr(4'd4, 10'h0AB, 0, 12);
        rd(4'd4, "R7");
        wr(4'd6, 10'h234, 0, 20);
        rd(4'd6, "R7");
        // R8: peak tracking disabled
        pulse(0, 10);
        rd(4'd10, "R8");
        wr(4'd14, 10'h020, 0, 16);
        pulse(0, 40); pulse(0, 20); pulse(0, 30); pulse(1, 50);
        // R6: reserved-bit read returns 0 and keeps the peak
        xfer({4'd10, 1'b0, 1'b1, 10'h0}, 16, rv);
        chk("R6", "reserved read", int'(rv), 0);
        cmp_en = 1;
        rd(4'd10, "R9");
        rd(4'd10, "R10");
        rd(4'd11, "R8");
        // R10: level held valid across the read
        @(negedge clk);
        lvl[5:0] = 6'd12;
        lvl_vld[0] = 1'b1;
        m_peak[0] = 12;
        repeat (4) @(negedge clk);
        xfer({4'd10, 1'b0, 1'b0, 10'h0}, 16, rv);
        chk("R10", "read with live level", int'(rv), 12 << 4);
        lvl_vld[0] = 1'b0;
        cmp_en = 1;
        rd(4'd10, "R10");
        repeat (10) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule